// File: doc/BRIEF.md
# Dual-Side Interprocessor Mailbox

This block joins two processors, called side A and side B, through a small set of memory-mapped registers. Each side has its own word-addressed register port and receives its own bank of 16 interrupt sources. A side signals its peer by writing a raise register. The receiving side inspects the pending bits, masks the sources it does not want, and acknowledges serviced sources with write-one-to-clear. Each side has one combined interrupt output. It is high while any pending source of that side is unmasked.

Beside the interrupt banks sits a small array of 32-bit message registers that both sides can read and write. A control register carries a software reset bit. The bit returns every piece of mailbox state to its reset value and then clears itself.

The register map is the same on both ports, with word addresses. Control is at 0, raise at 1, acknowledge at 2, mask at 3 and status at 4. Message register k is at `SHR_BASE + k`. In every receiving-side register, source n sits at bit n+16. In every register that acts on the peer's bank, source n sits at bit n.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both mask registers read 0xFFFF0000, both status registers read 0, all message registers read 0 and both interrupt outputs are low.
- R2: A write to the raise register (word 1) with bit n (n in 0..15) set makes the peer's pending bit n 1. The peer's status register (word 4) then shows it at bit n+16.
- R3: A write to a side's own raise register with bit n+16 set makes that side's own pending bit n 1 again.
- R4: Writing 1s to bits 31:16 of the acknowledge register (word 2) clears the matching pending bits of the writing side. Writing 1s to bits 15:0 clears the matching pending bits of the peer's bank, so 0x0000FFFF clears all 16 of them. Zero bits leave pending bits unchanged, and pending bits hold until they are cleared.
- R5: The mask register (word 3) holds one bit per source at bits 31:16, and 1 blocks the source. A side's interrupt output is high exactly when some pending bit of that side has its mask bit at 0.
- R6: When a raise and an acknowledge hit the same pending bit in the same cycle, the bit ends up set.
- R7: Message register k is read and written from either side at word `SHR_BASE + k`. When both sides write the same message register in the same cycle, side A's data is kept.
- R8: Writing 1 to bit 0 of the control register (word 0) makes that bit read 1 for one cycle. In the next cycle all pending bits, masks and message registers return to their R1 values and the bit reads 0. Writing 0 has no effect.
- R9: Reads of unmapped words and of the write-only raise and acknowledge registers return 0. Writes to the status register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 1 | Side A access select |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | AW | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational |
| a_irq | output | 1 | Side A combined interrupt |
| b_sel | input | 1 | Side B access select |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | AW | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational |
| b_irq | output | 1 | Side B combined interrupt |

## Verification
Three functions of this block can fall into one cycle: a raise, from the peer or from the side itself, and an acknowledge on the same pending bit. A write by each side to the same message register can also coincide. The bench drives both ports in the same clock cycle to provoke these collisions. It first raises and acknowledges the same bit from opposite sides, once through the peer raise and once through the own re-raise. It then writes the same message word from both ports. Each outcome is judged through the status register and the interrupt line: the bit must survive. Through a read-back of the message word, side A's data must be the one kept.

// File: rtl/ipcmb_pkg.sv
package ipcmb_pkg;

    localparam int SRC_N = 16;
    localparam int DW    = 32;

    localparam int OFS_CTRL  = 0;
    localparam int OFS_RAISE = 1;
    localparam int OFS_ACK   = 2;
    localparam int OFS_MASK  = 3;
    localparam int OFS_STAT  = 4;

    typedef struct packed {
        logic          ctl_we;
        logic          raise_we;
        logic          ack_we;
        logic          mask_we;
        logic          shr_we;
        logic [DW-1:0] wd;
    } side_wr_t;

    function automatic logic [DW-1:0] hi_field(input logic [SRC_N-1:0] v);
        return {v, {(DW-SRC_N){1'b0}}};
    endfunction

    function automatic logic [SRC_N-1:0] gate16(input logic en, input logic [SRC_N-1:0] v);
        return en ? v : '0;
    endfunction

endpackage

// File: rtl/ipcmb_bank.sv
module ipcmb_bank
    import ipcmb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  side_wr_t         own,
    input  side_wr_t         peer,
    output logic [SRC_N-1:0] pend_o,
    output logic [SRC_N-1:0] mask_o,
    output logic             irq_o
);

    logic [SRC_N-1:0] pend_q, mask_q, set_v, clr_v;

    always_comb begin
        set_v = gate16(own.raise_we, own.wd[DW-1:SRC_N]) | gate16(peer.raise_we, peer.wd[SRC_N-1:0]);
        clr_v = gate16(own.ack_we,   own.wd[DW-1:SRC_N]) | gate16(peer.ack_we,   peer.wd[SRC_N-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '1;
        end else begin
            pend_q <= (pend_q & ~clr_v) | set_v;
            if (own.mask_we)
                mask_q <= own.wd[DW-1:SRC_N];
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign irq_o  = |(pend_q & ~mask_q);

    AST_RESET_VALUES: assert property (@(posedge clk) $past(rst) |-> (pend_q == '0 && mask_q == '1)); // R1
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_v) |=> ((pend_q & $past(set_v)) == $past(set_v))); // R6
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (|(clr_v & ~set_v)) |=> ((pend_q & $past(clr_v & ~set_v)) == '0)); // R4
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(pend_q & ~clr_v)) == $past(pend_q & ~clr_v))); // R4
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq_o); // R5

endmodule

// File: rtl/ipcmb_shared.sv
module ipcmb_shared
    import ipcmb_pkg::*;
#(
    parameter int NUM_SHR = 4,
    localparam int SIW = (NUM_SHR > 1) ? $clog2(NUM_SHR) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        a_we,
    input  logic [SIW-1:0]              a_idx,
    input  logic [DW-1:0]               a_wd,
    input  logic                        b_we,
    input  logic [SIW-1:0]              b_idx,
    input  logic [DW-1:0]               b_wd,
    output logic [NUM_SHR-1:0][DW-1:0]  regs_o
);

    for (genvar k = 0; k < NUM_SHR; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                regs_o[k] <= '0;
            else if (a_we && a_idx == SIW'(k))
                regs_o[k] <= a_wd;
            else if (b_we && b_idx == SIW'(k))
                regs_o[k] <= b_wd;
        end
    end

    AST_SHR_A_WINS: assert property (@(posedge clk) disable iff (rst)
        a_we |=> (regs_o[$past(a_idx)] == $past(a_wd))); // R7

endmodule

// File: rtl/ipcmb_regport.sv
module ipcmb_regport
    import ipcmb_pkg::*;
#(
    parameter int AW       = 6,
    parameter int NUM_SHR  = 4,
    parameter int SHR_BASE = 8,
    localparam int SIW = (NUM_SHR > 1) ? $clog2(NUM_SHR) : 1
) (
    input  logic                        sel,
    input  logic                        wr,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    input  logic                        srst_bit,
    input  logic [SRC_N-1:0]            pend,
    input  logic [SRC_N-1:0]            mask,
    input  logic [NUM_SHR-1:0][DW-1:0]  shr,
    output side_wr_t                    wr_o,
    output logic [SIW-1:0]              shr_idx,
    output logic [DW-1:0]               rdata
);

    logic en, hit_shr;
    int   a;

    always_comb begin
        a       = int'(addr);
        en      = sel && wr;
        hit_shr = (a >= SHR_BASE) && (a < SHR_BASE + NUM_SHR);
        shr_idx = hit_shr ? SIW'(a - SHR_BASE) : '0;

        wr_o.ctl_we   = en && a == OFS_CTRL;
        wr_o.raise_we = en && a == OFS_RAISE;
        wr_o.ack_we   = en && a == OFS_ACK;
        wr_o.mask_we  = en && a == OFS_MASK;
        wr_o.shr_we   = en && hit_shr;
        wr_o.wd       = wdata;

        rdata = '0;
        if (sel && !wr) begin
            if (hit_shr)
                rdata = shr[shr_idx];
            else if (a == OFS_CTRL)
                rdata = {{(DW-1){1'b0}}, srst_bit};
            else if (a == OFS_MASK)
                rdata = hi_field(mask);
            else if (a == OFS_STAT)
                rdata = hi_field(pend);
        end
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipcmb_pkg::*;
#(
    parameter int AW       = 6,
    parameter int NUM_SHR  = 4,
    parameter int SHR_BASE = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_sel,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [31:0]   a_wdata,
    output logic [31:0]   a_rdata,
    output logic          a_irq,
    input  logic          b_sel,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [31:0]   b_wdata,
    output logic [31:0]   b_rdata,
    output logic          b_irq
);

    localparam int SIW = (NUM_SHR > 1) ? $clog2(NUM_SHR) : 1;

    logic [1:0]             sel, wr, irq;
    logic [AW-1:0]          addr  [2];
    logic [DW-1:0]          wdata [2];
    logic [DW-1:0]          rdata [2];
    side_wr_t               wrs   [2];
    logic [SIW-1:0]         sidx  [2];
    logic [SRC_N-1:0]       pend  [2];
    logic [SRC_N-1:0]       mask  [2];
    logic [NUM_SHR-1:0][DW-1:0] shr;
    logic                   srst_q, rst_eff, srst_req;

    assign sel      = {b_sel, a_sel};
    assign wr       = {b_wr, a_wr};
    assign addr[0]  = a_addr;
    assign addr[1]  = b_addr;
    assign wdata[0] = a_wdata;
    assign wdata[1] = b_wdata;
    assign a_rdata  = rdata[0];
    assign b_rdata  = rdata[1];
    assign a_irq    = irq[0];
    assign b_irq    = irq[1];

    assign rst_eff  = rst || srst_q;
    assign srst_req = (wrs[0].ctl_we && wrs[0].wd[0]) || (wrs[1].ctl_we && wrs[1].wd[0]);

    always_ff @(posedge clk) begin
        if (rst)
            srst_q <= 1'b0;
        else
            srst_q <= !srst_q && srst_req;
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        ipcmb_regport #(.AW(AW), .NUM_SHR(NUM_SHR), .SHR_BASE(SHR_BASE)) u_port (
            .sel(sel[s]), .wr(wr[s]), .addr(addr[s]), .wdata(wdata[s]),
            .srst_bit(srst_q), .pend(pend[s]), .mask(mask[s]), .shr(shr),
            .wr_o(wrs[s]), .shr_idx(sidx[s]), .rdata(rdata[s])
        );

        ipcmb_bank u_bank (
            .clk(clk), .rst(rst_eff), .own(wrs[s]), .peer(wrs[1-s]),
            .pend_o(pend[s]), .mask_o(mask[s]), .irq_o(irq[s])
        );
    end

    ipcmb_shared #(.NUM_SHR(NUM_SHR)) u_shr (
        .clk(clk), .rst(rst_eff),
        .a_we(wrs[0].shr_we), .a_idx(sidx[0]), .a_wd(wrs[0].wd),
        .b_we(wrs[1].shr_we), .b_idx(sidx[1]), .b_wd(wrs[1].wd),
        .regs_o(shr)
    );

    AST_SRST_PULSE: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> !srst_q); // R8
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (pend[0] == '0 && pend[1] == '0 && mask[0] == '1 && shr == '0)); // R8

endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;

    localparam int AW = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
    logic a_irq, b_irq;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ipc_mailbox #(.AW(AW), .NUM_SHR(4), .SHR_BASE(8)) uut (
        .clk(clk), .rst(rst),
        .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
        .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
    );

    typedef struct packed {
        logic        side;
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 6'd3,  32'h0,         32'hFFFF0000, 4'd1}, // R1 mask reset
        '{1'b0, 1'b0, 6'd4,  32'h0,         32'h00000000, 4'd1}, // R1 status reset
        '{1'b1, 1'b1, 6'd1,  32'h00000005,  32'h0,        4'd2}, // R2 B raises A 0,2
        '{1'b0, 1'b0, 6'd4,  32'h0,         32'h00050000, 4'd2}, // R2
        '{1'b0, 1'b1, 6'd3,  32'hFFFA0000,  32'h0,        4'd5}, // R5 unmask 0,2
        '{1'b0, 1'b0, 6'd3,  32'h0,         32'hFFFA0000, 4'd5}, // R5
        '{1'b0, 1'b1, 6'd2,  32'h00010000,  32'h0,        4'd4}, // R4 ack own 0
        '{1'b0, 1'b0, 6'd4,  32'h0,         32'h00040000, 4'd4}, // R4
        '{1'b0, 1'b1, 6'd4,  32'hFFFF0000,  32'h0,        4'd9}, // R9 status write
        '{1'b0, 1'b0, 6'd4,  32'h0,         32'h00040000, 4'd9}, // R9 ignored
        '{1'b0, 1'b1, 6'd8,  32'hDEADBEEF,  32'h0,        4'd7}, // R7
        '{1'b1, 1'b0, 6'd8,  32'h0,         32'hDEADBEEF, 4'd7}, // R7
        '{1'b1, 1'b1, 6'd11, 32'h12345678,  32'h0,        4'd7}, // R7
        '{1'b0, 1'b0, 6'd11, 32'h0,         32'h12345678, 4'd7}, // R7
        '{1'b0, 1'b0, 6'd12, 32'h0,         32'h00000000, 4'd9}, // R9 unmapped
        '{1'b0, 1'b0, 6'd1,  32'h0,         32'h00000000, 4'd9}, // R9 raise reads 0
        '{1'b0, 1'b1, 6'd1,  32'h00020000,  32'h0,        4'd3}, // R3 own re-raise 1
        '{1'b0, 1'b0, 6'd4,  32'h0,         32'h00060000, 4'd3}, // R3
        '{1'b1, 1'b1, 6'd2,  32'h0000FFFF,  32'h0,        4'd4}, // R4 peer clear all
        '{1'b0, 1'b0, 6'd4,  32'h0,         32'h00000000, 4'd4}, // R4
        '{1'b0, 1'b1, 6'd1,  32'h00008001,  32'h0,        4'd2}, // R2 A raises B 15,0
        '{1'b1, 1'b0, 6'd4,  32'h0,         32'h80010000, 4'd2}, // R2
        '{1'b1, 1'b0, 6'd3,  32'h0,         32'hFFFF0000, 4'd1}  // R1 B mask intact
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic idle();
        a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
    endtask

    // drives at negedge, lets the write commit at posedge, returns at next negedge
    task automatic op(input logic side, input logic w, input logic [5:0] ad, input logic [31:0] d,
                      output logic [31:0] rd);
        if (side == 1'b0) begin a_sel = 1; a_wr = w; a_addr = ad; a_wdata = d; end
        else              begin b_sel = 1; b_wr = w; b_addr = ad; b_wdata = d; end
        #1 rd = (side == 1'b0) ? a_rdata : b_rdata;
        @(posedge clk); #1 idle();
        @(negedge clk);
    endtask

    task automatic dual(input logic [5:0] aa, input logic [31:0] ad, input logic [5:0] ba, input logic [31:0] bd);
        a_sel = 1; a_wr = 1; a_addr = aa; a_wdata = ad;
        b_sel = 1; b_wr = 1; b_addr = ba; b_wdata = bd;
        @(posedge clk); #1 idle();
        @(negedge clk);
    endtask

    task automatic rd_chk(input logic side, input logic [5:0] ad, input logic [31:0] exp, input string req);
        logic [31:0] r;
        op(side, 1'b0, ad, 32'h0, r);
        check(req, r, exp);
    endtask

    task automatic wr_op(input logic side, input logic [5:0] ad, input logic [31:0] d);
        logic [31:0] r;
        op(side, 1'b1, ad, d, r);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);

        check("R1 a_irq", {31'b0, a_irq}, 32'h0);
        check("R1 b_irq", {31'b0, b_irq}, 32'h0);
        rd_chk(1'b0, 6'd8, 32'h0, "R1 shared");

        for (int i = 0; i < NV; i++) begin
            logic [31:0] r;
            op(VECS[i].side, VECS[i].wr, VECS[i].addr, VECS[i].data, r);
            if (!VECS[i].wr)
                check($sformatf("R%0d vec %0d", VECS[i].req, i), r, VECS[i].exp);
        end

        check("R5 masked a_irq", {31'b0, a_irq}, 32'h0);
        check("R5 masked b_irq", {31'b0, b_irq}, 32'h0);
        wr_op(1'b1, 6'd3, 32'hFFFE0000);
        check("R5 unmasked b_irq", {31'b0, b_irq}, 32'h1);
        wr_op(1'b1, 6'd2, 32'h00010000);
        check("R4 ack drops b_irq", {31'b0, b_irq}, 32'h0);

        dual(6'd1, 32'h00000001, 6'd2, 32'h00010000);
        rd_chk(1'b1, 6'd4, 32'h80010000, "R6 peer raise vs ack");
        check("R6 b_irq", {31'b0, b_irq}, 32'h1);

        dual(6'd1, 32'h00010000, 6'd2, 32'h00000001);
        rd_chk(1'b0, 6'd4, 32'h00010000, "R6 own re-raise vs peer ack");
        check("R3 a_irq", {31'b0, a_irq}, 32'h1);

        dual(6'd9, 32'h11111111, 6'd9, 32'h22222222);
        rd_chk(1'b1, 6'd9, 32'h11111111, "R7 side A wins");

        wr_op(1'b1, 6'd0, 32'h0);
        rd_chk(1'b0, 6'd8, 32'hDEADBEEF, "R8 zero write no reset");

        wr_op(1'b1, 6'd0, 32'h1);
        rd_chk(1'b0, 6'd0, 32'h1, "R8 bit reads 1");
        rd_chk(1'b1, 6'd0, 32'h0, "R8 self clear");
        rd_chk(1'b1, 6'd3, 32'hFFFF0000, "R8 mask reset");
        rd_chk(1'b1, 6'd4, 32'h0, "R8 status reset");
        rd_chk(1'b0, 6'd8, 32'h0, "R8 shared reset");
        check("R8 a_irq", {31'b0, a_irq}, 32'h0);
        check("R8 b_irq", {31'b0, b_irq}, 32'h0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule